// File: doc/BRIEF.md
# Early-Terminating Majority Logic Decoder

This block turns a 15-bit word read back from a protected memory into its 7 payload bits. The word belongs to a cyclic (15,7) Euclidean-geometry low-density parity-check code with minimum distance 5. The decoder therefore repairs any one or two flipped bits, whether they sit in the payload or in the check bits.

When `start` is sampled in the idle state, the incoming word goes through a full one-cycle parity test. A word that passes is answered at once. A word that fails is loaded into a circulating register for serial majority-logic repair. Four parity sums that are orthogonal on the output-end bit vote on whether that bit is wrong. The bit is fixed if needed and fed back at the input end as the register rotates. After fifteen rotations every position has been visited and the word is back in its original alignment, now corrected.

The controller has two states. `ST_IDLE` waits for `start`. Its transitions are *accept-clean*, which stays in `ST_IDLE` and pulses `done`, and *accept-dirty*, which goes to `ST_ROTATE`. `ST_ROTATE` steps a rotation counter. Its transitions are *step*, which stays in `ST_ROTATE`, and *finish*, which returns to `ST_IDLE` on the 15th rotation and pulses `done`.

Top module: `mld_decoder`

## Requirements
- R1: While reset is low and on the first cycle after it is released, `done`, `err_det` and `data_out` are all 0.
- R2: Code word bit i is `code_in[i]`. Check row r (r = 0..14) is the XOR of bits (r+0), (r+1), (r+3) and (r+7), each taken mod 15. The payload sits in bits 14..8, and `data_out[6:0]` equals `code_in[14:8]` of the corrected word.
- R3: A start with all 15 check rows zero gives `done` in the cycle right after the accepting edge, with `err_det` = 0.
- R4: A start with any non-zero check row spends the accepting cycle plus exactly 15 rotate cycles. `done` rises after the 15th clock edge that follows the accepting edge, with `err_det` = 1.
- R5: Every word within Hamming distance 2 of a valid code word returns that code word's payload, whatever the error positions.
- R6: `done` is high for one cycle per decode. `data_out` and `err_det` change only on the edge that raises `done`, and hold until the next result.
- R7: A `start` seen while in `ST_ROTATE` is ignored. It produces no extra `done` and does not disturb the running result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to decode `code_in`; taken only when idle |
| code_in | input | 15 | Word read from memory |
| data_out | output | 7 | Corrected payload bits |
| done | output | 1 | One-cycle pulse: result valid |
| err_det | output | 1 | Set with `done` when the initial parity test failed |

## Verification
Every one of the 128 payloads is encoded and sent clean. This tells the one-cycle path apart from the serial path and confirms the bit placement. Eight payloads, including all-zero, all-one and two alternating patterns, are each sent with every single-bit flip and every pair of flips. Flips at the output end exercise the vote on the first rotation, and flips deep in the word exercise it on later rotations. Pairs that share one orthogonal sum separate the "at least three of four" rule from a simple "any sum set" rule. A clean `start` injected during a rotating decode shows whether the busy state really shields the register and the result.

// File: rtl/mld_pkg.sv
package mld_pkg;

    // code geometry
    localparam int unsigned CW_LEN   = 15;
    localparam int unsigned DATA_LEN = 7;
    localparam int unsigned CNT_W    = $clog2(CW_LEN);

    // base check row: ones at positions 0, 1, 3, 7; other rows are its rotations
    localparam logic [CW_LEN-1:0] CHECK_TAPS = 15'h008B;

    // check rows that all contain bit 14 and share no other bit
    localparam int unsigned ORTH_CNT = 4;
    localparam int unsigned VOTE_MIN = ORTH_CNT / 2 + 1;
    localparam logic [CW_LEN-1:0] ORTH_MASK [ORTH_CNT] = '{
        15'h4045,   // 14, 6, 2, 0
        15'h6022,   // 14, 13, 5, 1
        15'h5808,   // 14, 12, 11, 3
        15'h4580    // 14, 10, 8, 7
    };

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ROTATE = 1'b1
    } mld_state_e;

endpackage

// File: rtl/mld_syndrome.sv
module mld_syndrome
    import mld_pkg::*;
#(
    parameter int unsigned      N    = CW_LEN,
    parameter logic [N-1:0]     TAPS = CHECK_TAPS
) (
    input  logic [N-1:0] word,
    output logic         clean
);

    logic [N-1:0] chk;

    // one check row per cyclic rotation of the base taps
    for (genvar r = 0; r < N; r++) begin : g_row
        localparam logic [N-1:0] MASK = (TAPS << r) | (TAPS >> (N - r));
        assign chk[r] = ^(word & MASK);
    end

    assign clean = ~|chk;

endmodule

// File: rtl/mld_vote.sv
module mld_vote
    import mld_pkg::*;
#(
    parameter int unsigned N = CW_LEN
) (
    input  logic [N-1:0] word,
    output logic         flip
);

    localparam int unsigned SW = $clog2(ORTH_CNT + 1);

    logic [ORTH_CNT-1:0] sums;
    logic [SW-1:0]       ones;

    for (genvar s = 0; s < ORTH_CNT; s++) begin : g_sum
        assign sums[s] = ^(word & ORTH_MASK[s]);
    end

    always_comb begin
        ones = '0;
        for (int s = 0; s < ORTH_CNT; s++) begin
            ones = ones + SW'(sums[s]);
        end
    end

    assign flip = (ones >= SW'(VOTE_MIN));

endmodule

// File: rtl/mld_decoder.sv
module mld_decoder
    import mld_pkg::*;
#(
    parameter int unsigned N = CW_LEN,
    parameter int unsigned K = DATA_LEN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] code_in,
    output logic [K-1:0] data_out,
    output logic         done,
    output logic         err_det
);

    localparam int unsigned CW   = $clog2(N);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    mld_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [N-1:0]  shreg_q;
    logic [N-1:0]  rot_word;
    logic          syn_zero;
    logic          flip;
    logic          accept;
    logic          finish;

    mld_syndrome #(.N(N)) u_syn (
        .word  (code_in),
        .clean (syn_zero)
    );

    mld_vote #(.N(N)) u_vote (
        .word (shreg_q),
        .flip (flip)
    );

    // corrected output-end bit re-enters at position 0
    assign rot_word = {shreg_q[N-2:0], shreg_q[N-1] ^ flip};
    assign accept   = (state_q == ST_IDLE) && start;
    assign finish   = (state_q == ST_ROTATE) && (cnt_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept && !syn_zero) state_d = ST_ROTATE;
            ST_ROTATE: if (finish)              state_d = ST_IDLE;
            default:                            state_d = ST_IDLE;
        endcase
    end

    // state register and rotation counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept)
                cnt_q <= '0;
            else if (state_q == ST_ROTATE)
                cnt_q <= cnt_q + CW'(1);
        end
    end

    // circulating register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shreg_q <= '0;
        else if (accept)
            shreg_q <= code_in;
        else if (state_q == ST_ROTATE)
            shreg_q <= rot_word;
    end

    // result outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            err_det  <= 1'b0;
            data_out <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept && syn_zero) begin
                        done     <= 1'b1;
                        err_det  <= 1'b0;
                        data_out <= code_in[N-1 -: K];
                    end
                end
                ST_ROTATE: begin
                    if (finish) begin
                        done     <= 1'b1;
                        err_det  <= 1'b1;
                        data_out <= rot_word[N-1 -: K];
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mld_decoder_chk.sv
module mld_decoder_chk
    import mld_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input mld_state_e          state,
    input logic [CNT_W-1:0]    cnt,
    input logic                syn_zero,
    input logic [DATA_LEN-1:0] data_out,
    input logic                done,
    input logic                err_det
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(CW_LEN - 1);

    a_r3_clean_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && syn_zero) |=> (done && !err_det));

    a_r4_dirty_enters_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && !syn_zero) |=> (state == ST_ROTATE && cnt == '0 && !done));

    a_r4_rotate_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROTATE && cnt != LAST) |=>
            (state == ST_ROTATE && cnt == $past(cnt) + CNT_W'(1) && !done));

    a_r4_finish_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROTATE && cnt == LAST) |=> (state == ST_IDLE && done && err_det));

    a_r6_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(data_out) || !$stable(err_det)) |-> done);

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> !done);

endmodule

bind mld_decoder mld_decoder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .state    (state_q),
    .cnt      (cnt_q),
    .syn_zero (syn_zero),
    .data_out (data_out),
    .done     (done),
    .err_det  (err_det)
);

// File: tb/tb_mld_decoder.sv
module tb_mld_decoder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [14:0] code_in;
    logic [6:0]  data_out;
    logic        done;
    logic        err_det;

    always #5 clk = ~clk;

    mld_decoder dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .code_in  (code_in),
        .data_out (data_out),
        .done     (done),
        .err_det  (err_det)
    );

    typedef struct {
        logic [6:0] data;
        logic       err;
        int         lat;
        int         stamp;
        string      req;
    } exp_t;

    exp_t q[$];
    int   cyc    = 0;
    int   checks = 0;
    int   errors = 0;
    bit   ended  = 0;

    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // independent check rows (R2): row r uses bits r, r+1, r+3, r+7 mod 15
    function automatic logic [14:0] bench_syn(input logic [14:0] w);
        logic [14:0] s;
        for (int r = 0; r < 15; r++)
            s[r] = w[r % 15] ^ w[(r + 1) % 15] ^ w[(r + 3) % 15] ^ w[(r + 7) % 15];
        return s;
    endfunction

    // payload in bits 14..8, search the 8 check bits
    function automatic logic [15:0] bench_enc(input logic [6:0] d);
        for (int p = 0; p < 256; p++) begin
            logic [14:0] w;
            w = {d, p[7:0]};
            if (bench_syn(w) == '0) return {1'b1, w};
        end
        return '0;
    endfunction

    // monitor / scoreboard
    bit         hold_pend = 0;
    bit         prev_done = 0;
    logic [6:0] hold_data;
    logic       hold_err;

    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend) begin
                check(data_out == hold_data && err_det == hold_err, "R6", "result hold",
                      {24'd0, err_det, data_out}, {24'd0, hold_err, hold_data});
                hold_pend = 0;
            end
            if (done) begin
                if (q.size() == 0) begin
                    check(0, "R7", "unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    int   lat;
                    e   = q.pop_front();
                    lat = cyc - e.stamp;
                    check(data_out == e.data && err_det == e.err && lat == e.lat && !prev_done,
                          e.req, "data/err/latency",
                          (32'(lat) << 8) | {24'd0, err_det, data_out},
                          (32'(e.lat) << 8) | {24'd0, e.err, e.data});
                end
                hold_pend = 1;
                hold_data = data_out;
                hold_err  = err_det;
            end
            prev_done = done;
        end
    end

    // driver: push expectation, pulse start, optionally poke during busy
    task automatic send(input logic [14:0] w, input logic [6:0] d, input logic err,
                        input string req, input bit poke, input logic [14:0] poke_w);
        exp_t e;
        @(negedge clk);
        e.data  = d;
        e.err   = err;
        e.lat   = err ? 16 : 1;
        e.stamp = cyc;
        e.req   = req;
        q.push_back(e);
        start   = 1'b1;
        code_in = w;
        @(negedge clk);
        start   = 1'b0;
        code_in = '0;
        if (poke) begin
            repeat (4) @(negedge clk);
            start   = 1'b1;
            code_in = poke_w;
            @(negedge clk);
            start   = 1'b0;
            code_in = '0;
        end
        wait (q.size() == 0);
    endtask

    initial begin
        logic [6:0] words [8];
        logic [15:0] enc;
        logic [14:0] poke_w;
        rst_n   = 1'b0;
        start   = 1'b0;
        code_in = '0;
        repeat (3) @(negedge clk);
        check(done == 0 && err_det == 0 && data_out == 0, "R1", "in reset",
              {23'd0, done, err_det, data_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 0 && err_det == 0 && data_out == 0, "R1", "after release",
              {23'd0, done, err_det, data_out}, 32'd0);

        enc    = bench_enc(7'h33);
        poke_w = enc[14:0];

        // R2 R3: every payload, clean
        for (int d = 0; d < 128; d++) begin
            enc = bench_enc(7'(d));
            check(enc[15] == 1'b1, "R2", "bench encoder", {16'd0, enc}, 32'h8000);
            send(enc[14:0], 7'(d), 1'b0, "R2 R3 clean", 1'b0, '0);
        end

        words[0] = 7'h00; words[1] = 7'h7F; words[2] = 7'h55; words[3] = 7'h2A;
        for (int k = 4; k < 8; k++) words[k] = 7'($urandom());

        // R4 R5: every single and double flip
        for (int k = 0; k < 8; k++) begin
            enc = bench_enc(words[k]);
            for (int i = 0; i < 15; i++) begin
                send(enc[14:0] ^ (15'd1 << i), words[k], 1'b1,
                     (k == 0) ? "R4 R5 R7 single+poke" : "R4 R5 single",
                     k == 0, poke_w);
                for (int j = i + 1; j < 15; j++)
                    send(enc[14:0] ^ (15'd1 << i) ^ (15'd1 << j), words[k], 1'b1,
                         "R4 R5 double", 1'b0, '0);
            end
        end

        repeat (20) @(negedge clk);
        check(q.size() == 0, "R6", "pending results", 32'(q.size()), 32'd0);
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", q.size());
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule